// File: doc/BRIEF.md
# Memory-Windowed Context Switch Unit

This unit is the control core of a processor whose general registers live in external word memory, not in flip-flops. Inside the unit there are only three architectural registers: a window base pointer, a program counter and a status word. The sixteen 16-bit general registers occupy consecutive words that start at the window base. When the datapath asks for register *n*, the unit turns that request into one memory access at the base plus twice *n*.

The unit also performs the two context-switch operations. A *call* reads a two-word vector that gives a new window base and a new program counter. It then saves the caller's base, counter and status into the last three registers of the new window, and switches only after that. A *return* reads those three link registers of the current window and restores all three architectural registers at the same time. A series of calls builds a linked chain of saved contexts, one per window, with no stack pointer. Returns walk back along that chain.

All memory traffic uses one port. Each request is held until the memory raises ready. Commands are accepted only while the unit is idle, and a one-cycle completion pulse marks the end of each operation.

Top module: `ws_ctx_unit`

## Requirements
- R1: After reset the window base is 0x0100, the program counter 0x0000 and the status word 0x0000. Busy, done, rf_ack and mem_req are all low.
- R2: A register access to index n (0..15) is one memory access at byte address base + 2·n. Bit 0 of every memory address is zero.
- R3: A register write stores rf_wdata at that address. A register read returns the memory word on rf_rdata. rf_ack pulses for one cycle, in the cycle after the access completes.
- R4: A call (cmd_op = 0) first reads the word at the vector address with bit 0 cleared, then the word at vector + 2.
- R5: After its two reads, a call writes three words in order: the old base to new-base + 26, the old counter to new-base + 28, and the old status to new-base + 30.
- R6: After a call the base holds the first vector word with bit 0 cleared, the counter holds the second vector word, and the status is unchanged. Base, counter and status change only in the cycle in which done is high.
- R7: A return (cmd_op = 1) reads base + 26, base + 28 and base + 30 in that order. It then loads the base (bit 0 cleared), the counter and the status from those three words, all together.
- R8: mem_req, mem_addr, mem_we and mem_wdata stay stable while mem_req is high and mem_ready is low. An access completes on a clock edge where both are high.
- R9: busy is high from command acceptance until done. done lasts one cycle, and busy is low while done is high. While busy, cmd_valid and rf_req are ignored and cause no memory access. mem_req is low whenever the unit is idle.
- R10: When cmd_valid and rf_req arrive together in the idle state, the command wins and the register request is dropped.
- R11: Nested calls followed by the same number of returns restore every earlier base, counter and status, in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Context command request |
| cmd_op | input | 1 | 0 = call through vector, 1 = return |
| cmd_vec | input | 16 | Vector byte address for a call |
| rf_req | input | 1 | Datapath register access request |
| rf_we | input | 1 | 1 = register write, 0 = register read |
| rf_idx | input | 4 | Register index |
| rf_wdata | input | 16 | Register write data |
| rf_ack | output | 1 | One-cycle register access completion |
| rf_rdata | output | 16 | Register read data, valid with rf_ack |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ready | input | 1 | Memory completes the access at this edge |
| mem_rdata | input | 16 | Memory read data, valid with mem_ready |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle context command completion |
| wp | output | 16 | Current window base |
| pc | output | 16 | Current program counter |
| sr | output | 16 | Current status word |

## Verification
A wrong sequencer state shows on the memory port at once. The next request carries a wrong address or write flag, or there is an extra access or a missing one, and the bench's access log catches it within the operation. A bad holding register stays hidden until the commit edge. It then shows as a wrong base, counter or status in the cycle done rises, or as a wrong saved word in the link slots of the new window. An early commit changes the architectural outputs while busy is still high. The commit assertion flags that in the same cycle, and the bench flags it at the next falling edge.

// File: rtl/ws_ctx_pkg.sv
package ws_ctx_pkg;

    typedef enum logic [0:0] {
        OP_CALL = 1'b0,
        OP_RET  = 1'b1
    } ctx_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CV0,
        S_CV1,
        S_CS_WP,
        S_CS_PC,
        S_CS_SR,
        S_RL_WP,
        S_RL_PC,
        S_RL_SR,
        S_RF
    } ctx_st_e;

endpackage

// File: rtl/ws_addr_gen.sv
module ws_addr_gen #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:1] base_hi,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  addr
);
    localparam int PADW = W - IW - 1;

    always_comb begin
        addr = {base_hi, 1'b0} + {{PADW{1'b0}}, idx, 1'b0};
    end
endmodule

// File: rtl/ws_arch_regs.sv
module ws_arch_regs #(
    parameter int         W      = 16,
    parameter logic [W-1:0] RST_WP = 'h0100,
    parameter logic [W-1:0] RST_PC = 'h0000,
    parameter logic [W-1:0] RST_SR = 'h0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_ctx,
    input  logic         ld_sr,
    input  logic [W-1:0] wp_in,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] sr_in,
    output logic [W-1:0] wp_o,
    output logic [W-1:0] pc_o,
    output logic [W-1:0] sr_o
);
    typedef struct packed {
        logic [W-1:0] wp;
        logic [W-1:0] pc;
        logic [W-1:0] sr;
    } arch_t;

    arch_t arch_d, arch_q;

    always_comb begin
        arch_d = arch_q;
        if (ld_ctx) begin
            arch_d.wp = {wp_in[W-1:1], 1'b0};
            arch_d.pc = pc_in;
        end
        if (ld_sr) begin
            arch_d.sr = sr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arch_q <= '{wp: RST_WP, pc: RST_PC, sr: RST_SR};
        end else begin
            arch_q <= arch_d;
        end
    end

    assign wp_o = arch_q.wp;
    assign pc_o = arch_q.pc;
    assign sr_o = arch_q.sr;
endmodule

// File: rtl/ws_ctx_unit.sv
module ws_ctx_unit
    import ws_ctx_pkg::*;
#(
    parameter int           W      = 16,
    parameter int           NREG   = 16,
    parameter logic [W-1:0] RST_WP = 'h0100,
    parameter logic [W-1:0] RST_PC = 'h0000,
    parameter logic [W-1:0] RST_SR = 'h0000,
    localparam int          IW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_op,
    input  logic [W-1:0]  cmd_vec,
    input  logic          rf_req,
    input  logic          rf_we,
    input  logic [IW-1:0] rf_idx,
    input  logic [W-1:0]  rf_wdata,
    output logic          rf_ack,
    output logic [W-1:0]  rf_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic          mem_ready,
    input  logic [W-1:0]  mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  wp,
    output logic [W-1:0]  pc,
    output logic [W-1:0]  sr
);
    localparam logic [IW-1:0] LNK_WP = IW'(NREG - 3);
    localparam logic [IW-1:0] LNK_PC = IW'(NREG - 2);
    localparam logic [IW-1:0] LNK_SR = IW'(NREG - 1);

    typedef struct packed {
        ctx_st_e        st;
        logic [W-1:1]   vec;
        logic [W-1:0]   t_wp;
        logic [W-1:0]   t_pc;
        logic [W-1:0]   rf_wd;
        logic [W-1:0]   rf_rd;
        logic [IW-1:0]  rf_ix;
        logic           rf_wr;
        logic           done;
        logic           ack;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [W-1:1]  base_hi;
    logic [IW-1:0] ix;
    logic          ld_ctx, ld_sr;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.ack  = 1'b0;
        base_hi   = wp[W-1:1];
        ix        = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        ld_ctx    = 1'b0;
        ld_sr     = 1'b0;

        unique case (ctl_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    ctl_d.vec = cmd_vec[W-1:1];
                    ctl_d.st  = (ctx_op_e'(cmd_op) == OP_RET) ? S_RL_WP : S_CV0;
                end else if (rf_req) begin
                    ctl_d.rf_ix = rf_idx;
                    ctl_d.rf_wr = rf_we;
                    ctl_d.rf_wd = rf_wdata;
                    ctl_d.st    = S_RF;
                end
            end
            S_CV0: begin
                base_hi = ctl_q.vec;
                ix      = '0;
                mem_req = 1'b1;
                if (mem_ready) begin
                    ctl_d.t_wp = {mem_rdata[W-1:1], 1'b0};
                    ctl_d.st   = S_CV1;
                end
            end
            S_CV1: begin
                base_hi = ctl_q.vec;
                ix      = IW'(1);
                mem_req = 1'b1;
                if (mem_ready) begin
                    ctl_d.t_pc = mem_rdata;
                    ctl_d.st   = S_CS_WP;
                end
            end
            S_CS_WP, S_CS_PC, S_CS_SR: begin
                base_hi = ctl_q.t_wp[W-1:1];
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (ctl_q.st == S_CS_WP) begin
                    ix = LNK_WP; mem_wdata = wp;
                end else if (ctl_q.st == S_CS_PC) begin
                    ix = LNK_PC; mem_wdata = pc;
                end else begin
                    ix = LNK_SR; mem_wdata = sr;
                end
                if (mem_ready) begin
                    if (ctl_q.st == S_CS_WP) begin
                        ctl_d.st = S_CS_PC;
                    end else if (ctl_q.st == S_CS_PC) begin
                        ctl_d.st = S_CS_SR;
                    end else begin
                        ld_ctx     = 1'b1;
                        ctl_d.done = 1'b1;
                        ctl_d.st   = S_IDLE;
                    end
                end
            end
            S_RL_WP: begin
                ix      = LNK_WP;
                mem_req = 1'b1;
                if (mem_ready) begin
                    ctl_d.t_wp = mem_rdata;
                    ctl_d.st   = S_RL_PC;
                end
            end
            S_RL_PC: begin
                ix      = LNK_PC;
                mem_req = 1'b1;
                if (mem_ready) begin
                    ctl_d.t_pc = mem_rdata;
                    ctl_d.st   = S_RL_SR;
                end
            end
            S_RL_SR: begin
                ix      = LNK_SR;
                mem_req = 1'b1;
                if (mem_ready) begin
                    ld_ctx     = 1'b1;
                    ld_sr      = 1'b1;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = S_IDLE;
                end
            end
            S_RF: begin
                ix        = ctl_q.rf_ix;
                mem_req   = 1'b1;
                mem_we    = ctl_q.rf_wr;
                mem_wdata = ctl_q.rf_wd;
                if (mem_ready) begin
                    ctl_d.rf_rd = ctl_q.rf_wr ? ctl_q.rf_wd : mem_rdata;
                    ctl_d.ack   = 1'b1;
                    ctl_d.st    = S_IDLE;
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ws_addr_gen #(.W(W), .IW(IW)) u_addr (
        .base_hi (base_hi),
        .idx     (ix),
        .addr    (mem_addr)
    );

    ws_arch_regs #(.W(W), .RST_WP(RST_WP), .RST_PC(RST_PC), .RST_SR(RST_SR)) u_arch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_ctx (ld_ctx),
        .ld_sr  (ld_sr),
        .wp_in  (ctl_q.t_wp),
        .pc_in  (ctl_q.t_pc),
        .sr_in  (mem_rdata),
        .wp_o   (wp),
        .pc_o   (pc),
        .sr_o   (sr)
    );

    assign busy     = (ctl_q.st != S_IDLE);
    assign done     = ctl_q.done;
    assign rf_ack   = ctl_q.ack;
    assign rf_rdata = ctl_q.rf_rd;
endmodule

// File: rtl/ws_ctx_unit_chk.sv
module ws_ctx_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mem_req,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] mem_wdata,
    input logic         mem_ready,
    input logic         busy,
    input logic         done,
    input logic         rf_ack,
    input logic [W-1:0] wp,
    input logic [W-1:0] pc,
    input logic [W-1:0] sr
);
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_word_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_ack |=> !rf_ack);

    p_ctx_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({wp, pc, sr}) |-> done);
endmodule

bind ws_ctx_unit ws_ctx_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .busy      (busy),
    .done      (done),
    .rf_ack    (rf_ack),
    .wp        (wp),
    .pc        (pc),
    .sr        (sr)
);

// File: tb/tb_ws_ctx_unit.sv
module tb_ws_ctx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [15:0] cmd_vec = '0;
    logic        rf_req = 1'b0, rf_we = 1'b0;
    logic [3:0]  rf_idx = '0;
    logic [15:0] rf_wdata = '0;
    logic        rf_ack;
    logic [15:0] rf_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done;
    logic [15:0] wp, pc, sr;

    always #2 clk = ~clk;

    ws_ctx_unit dut (.*);

    // memory model with programmable wait states and an access log
    logic [15:0] mem [0:255];
    int          lat = 0;
    int          wcnt = 0;
    logic        bk_we = 1'b0;
    logic [15:0] bk_a = '0, bk_d = '0;
    logic [15:0] log_a [0:255];
    logic        log_w [0:255];
    logic [15:0] log_d [0:255];
    int          log_n = 0;

    assign mem_ready = mem_req && (wcnt >= lat);
    assign mem_rdata = mem[mem_addr[8:1]];

    always @(posedge clk) begin
        if (bk_we) mem[bk_a[8:1]] <= bk_d;
        if (mem_req && mem_ready) begin
            if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
            log_a[log_n[7:0]] <= mem_addr;
            log_w[log_n[7:0]] <= mem_we;
            log_d[log_n[7:0]] <= mem_we ? mem_wdata : mem_rdata;
            log_n <= log_n + 1;
            wcnt  <= 0;
        end else if (mem_req) begin
            wcnt <= wcnt + 1;
        end
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); bk_we = 1'b1; bk_a = a; bk_d = d;
        @(negedge clk); bk_we = 1'b0;
    endtask

    task automatic exp_acc(input int k, input logic [15:0] a, input logic w,
                           input logic [15:0] d, input string req);
        chk(log_a[k[7:0]] == a, req, "access address", 32'(log_a[k[7:0]]), 32'(a));
        chk(log_w[k[7:0]] == w && log_d[k[7:0]] == d, req, "access kind/data",
            {15'd0, log_w[k[7:0]], log_d[k[7:0]]}, {15'd0, w, d});
    endtask

    task automatic reg_acc(input logic we, input logic [3:0] ix, input logic [15:0] wd,
                           output logic [15:0] rd, output int base);
        int g;
        base = log_n;
        @(negedge clk); rf_req = 1'b1; rf_we = we; rf_idx = ix; rf_wdata = wd;
        @(negedge clk); rf_req = 1'b0;
        g = 0;
        while (!rf_ack && g < 40) begin @(negedge clk); g++; end
        chk(g < 40, "R3", "register access timeout", 32'(g), 32'd0);
        rd = rf_rdata;
        @(negedge clk);
        chk(!rf_ack, "R3", "rf_ack width", 32'(rf_ack), 32'd0);
    endtask

    // mode 0: plain, 1: poke cmd/rf while busy, 2: rf_req together with cmd
    task automatic run_cmd(input logic op, input logic [15:0] v, input int mode,
                           output int nacc, output bit early, output bit stray, output int base);
        int g;
        logic [15:0] w0, p0, s0;
        base = log_n; w0 = wp; p0 = pc; s0 = sr; early = 0; stray = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_vec = v;
        if (mode == 2) begin rf_req = 1'b1; rf_we = 1'b1; rf_idx = 4'd0; rf_wdata = 16'hDEAD; end
        @(negedge clk);
        cmd_valid = (mode == 1); cmd_op = ~op;
        rf_req = (mode == 1); rf_we = 1'b1; rf_idx = 4'd0; rf_wdata = 16'hDEAD;
        g = 0;
        while (!done && g < 60) begin
            if (wp != w0 || pc != p0 || sr != s0) early = 1;
            if (rf_ack) stray = 1;
            chk(busy, "R9", "busy during operation", 32'(busy), 32'd1);
            @(negedge clk); g++;
            if (g == 2) begin cmd_valid = 1'b0; rf_req = 1'b0; end
        end
        cmd_valid = 1'b0; rf_req = 1'b0;
        chk(g < 60, "R9", "command timeout", 32'(g), 32'd0);
        chk(!busy, "R9", "busy low with done", 32'(busy), 32'd0);
        nacc = log_n - base;
        @(negedge clk);
        chk(!done && !busy, "R9", "done single cycle", {30'd0, done, busy}, 32'd0);
        if (rf_ack) stray = 1;
    endtask

    localparam int NV = 6;
    // {latency[3:0], index[3:0], data[15:0]}
    localparam logic [23:0] VECS [NV] = '{
        {4'd0, 4'd0,  16'h1234},
        {4'd1, 4'd15, 16'hBEEF},
        {4'd2, 4'd7,  16'h0F0F},
        {4'd0, 4'd13, 16'h8001},
        {4'd1, 4'd1,  16'hFFFF},
        {4'd2, 4'd14, 16'h0000}
    };

    task automatic run_all();
        logic [15:0] rd;
        int base, nacc;
        bit early, stray;

        // vectors and reset
        poke(16'h0010, 16'h0041);
        poke(16'h0012, 16'h0222);
        poke(16'h0020, 16'h00C0);
        poke(16'h0022, 16'h0333);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wp == 16'h0100 && pc == 16'h0000 && sr == 16'h0000, "R1", "reset context",
            {wp, pc ^ sr}, {16'h0100, 16'h0000});
        chk(!busy && !done && !rf_ack && !mem_req, "R1", "reset flags",
            {28'd0, busy, done, rf_ack, mem_req}, 32'd0);

        // table walk: register write then read back (R2, R3, R8 via latency)
        for (int i = 0; i < NV; i++) begin
            lat = int'(VECS[i][23:20]);
            reg_acc(1'b1, VECS[i][19:16], VECS[i][15:0], rd, base);
            chk(log_n - base == 1, "R2", "one access per write", 32'(log_n - base), 32'd1);
            exp_acc(base, 16'h0100 + {11'd0, VECS[i][19:16], 1'b0}, 1'b1, VECS[i][15:0], "R2");
            reg_acc(1'b0, VECS[i][19:16], 16'h0000, rd, base);
            chk(rd == VECS[i][15:0], "R3", "register read-back", 32'(rd), 32'(VECS[i][15:0]));
            exp_acc(base, 16'h0100 + {11'd0, VECS[i][19:16], 1'b0}, 1'b0, VECS[i][15:0], "R3");
        end

        // seed link slots of the reset window (base bit 0 set on purpose)
        lat = 1;
        reg_acc(1'b1, 4'd13, 16'h0181, rd, base);
        reg_acc(1'b1, 4'd14, 16'h0456, rd, base);
        reg_acc(1'b1, 4'd15, 16'hA5C3, rd, base);

        // R7: return from reset window
        run_cmd(1'b1, 16'h0000, 0, nacc, early, stray, base);
        chk(nacc == 3, "R7", "return access count", 32'(nacc), 32'd3);
        exp_acc(base,     16'h011A, 1'b0, 16'h0181, "R7");
        exp_acc(base + 1, 16'h011C, 1'b0, 16'h0456, "R7");
        exp_acc(base + 2, 16'h011E, 1'b0, 16'hA5C3, "R7");
        chk(wp == 16'h0180 && pc == 16'h0456 && sr == 16'hA5C3, "R7", "return context",
            {wp, pc}, {16'h0180, 16'h0456});
        chk(!early, "R7", "return committed early", 32'(early), 32'd0);

        // R4, R5, R6 (R8 with two wait states): call through unaligned vector
        lat = 2;
        run_cmd(1'b0, 16'h0011, 0, nacc, early, stray, base);
        chk(nacc == 5, "R4", "call access count", 32'(nacc), 32'd5);
        exp_acc(base,     16'h0010, 1'b0, 16'h0041, "R4");
        exp_acc(base + 1, 16'h0012, 1'b0, 16'h0222, "R4");
        exp_acc(base + 2, 16'h005A, 1'b1, 16'h0180, "R5");
        exp_acc(base + 3, 16'h005C, 1'b1, 16'h0456, "R5");
        exp_acc(base + 4, 16'h005E, 1'b1, 16'hA5C3, "R5");
        chk(wp == 16'h0040 && pc == 16'h0222 && sr == 16'hA5C3, "R6", "call context",
            {wp, pc}, {16'h0040, 16'h0222});
        chk(!early, "R6", "call committed early", 32'(early), 32'd0);

        // R9: nested call with commands and register requests poked while busy
        lat = 0;
        run_cmd(1'b0, 16'h0020, 1, nacc, early, stray, base);
        chk(nacc == 5, "R9", "accesses with ignored requests", 32'(nacc), 32'd5);
        chk(!stray, "R9", "rf_ack while busy", 32'(stray), 32'd0);
        exp_acc(base + 2, 16'h00DA, 1'b1, 16'h0040, "R5");
        exp_acc(base + 3, 16'h00DC, 1'b1, 16'h0222, "R5");
        exp_acc(base + 4, 16'h00DE, 1'b1, 16'hA5C3, "R5");
        chk(wp == 16'h00C0 && pc == 16'h0333, "R6", "nested call context",
            {wp, pc}, {16'h00C0, 16'h0333});

        // R11: unwind the chain
        lat = 1;
        run_cmd(1'b1, 16'h0000, 0, nacc, early, stray, base);
        chk(wp == 16'h0040 && pc == 16'h0222 && sr == 16'hA5C3, "R11", "first unwind",
            {wp, pc}, {16'h0040, 16'h0222});

        // R10: return and register write in the same idle cycle
        run_cmd(1'b1, 16'h0000, 2, nacc, early, stray, base);
        chk(nacc == 3 && !log_w[base[7:0]] && !log_w[base[7:0] + 8'd1] && !log_w[base[7:0] + 8'd2],
            "R10", "command wins, no write", 32'(nacc), 32'd3);
        chk(!stray, "R10", "dropped register request acked", 32'(stray), 32'd0);
        chk(wp == 16'h0180 && pc == 16'h0456 && sr == 16'hA5C3, "R11", "second unwind",
            {wp, pc}, {16'h0180, 16'h0456});
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                nchk++; nfail++;
                $display("FAIL R9 watchdog expired actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule